// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and a calendar in binary-coded decimal. It advances one second on every cycle in which the 1 Hz tick enable is high. The tick comes from a slow clock divided down outside the block. Seconds, minutes, hours, day of month, month, two-digit year and day of week are all counted directly in BCD. Month lengths and leap years are handled without software help. The hour counter runs either 00 to 23 or 12-hour with an afternoon bit.

Three further features sit around the calendar. A time-of-day alarm sets a sticky flag when a tick lands on the programmed time. A wakeup down-counter, also driven by the tick, emits a single-cycle pulse at a programmable period. A bank of backup words keeps user data and is erased at once when the tamper input is high. Software reaches everything through a synchronous write port and a combinational read port that share one word address map.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the clock reads 00:00:00 in 24-hour mode, the calendar reads day 01, month 01, year 00, weekday 1, and the control word, alarm flag and wakeup pulse are zero. The time word (address 0) holds seconds in [7:0], minutes in [15:8], hours in [23:16] and the afternoon bit in [24]. The calendar word (address 1) holds the day in [7:0], the month in [15:8], the year in [23:16] and the weekday in [26:24]. All fields are BCD.
- R2: In 24-hour mode (control bit 0 clear) each tick adds one second, with seconds and minutes wrapping 59 to 00 and hours wrapping 23 to 00. The day advances only on the 23:59:59 tick.
- R3: In 12-hour mode (control bit 0 set) hours count 12, 01, …, 11. The afternoon bit toggles when hours go from 11 to 12. The day advances only when 11:59:59 with the afternoon bit set becomes 12:00:00 with the bit clear.
- R4: On a day advance the day of month wraps to 01 after 31, or after 30 for months 04, 06, 09 and 11. For month 02 it wraps after 29 when the year is divisible by 4, and after 28 otherwise.
- R5: When the day wraps, the month advances, going from 12 to 01. On that wrap the year also advances, going from 99 to 00. The weekday advances on every day advance and goes from 7 to 1.
- R6: A write to the time word or the calendar word loads that word on the next edge. No tick is taken in that cycle, so the written value is read back unchanged.
- R7: With alarm enable (control bit 1) set, a tick that brings seconds, minutes and hours to the alarm word (address 3, same layout as the time word) sets the alarm flag. The afternoon bit also has to match in 12-hour mode. The flag stays set and reads back in control bit 8. Writing the control word with bit 8 set clears it. With enable clear the flag never sets.
- R8: With wakeup enable (control bit 2) set and reload value N (address 4), the wakeup output is a one-cycle pulse on every (N+1)-th tick counted from enabling. Address 4 reads back N.
- R9: Backup word i is written and read at address 32+i, for i from 0 to 19.
- R10: While the tamper input is high, every backup word is cleared, and a backup write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle enable, one per second |
| tamper | input | 1 | High clears all backup words |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| alarm_flag | output | 1 | Sticky alarm match flag |
| wake_pulse | output | 1 | One-cycle periodic wakeup pulse |

## Verification
A wrong carry or wrap in the counter chain shows up in the time or calendar word on the read port in the cycle after the offending tick. A missed or extra carry offsets every later reading, so even sparse sampling during a one-day run catches it. Month-length and leap-year faults appear only on the one tick that crosses a month boundary. The bench therefore places the calendar at the last second of every month of all hundred years and reads the next day. A wrong wakeup count shifts the pulse off its tick, and the pulse is seen in the same cycle that tick is consumed.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic       pm;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_t;

  typedef struct packed {
    logic [2:0] wday;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
  } cal_t;

  // add one to a two-digit BCD value, low digit carries at 9
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_val(input logic [7:0] v);
    return ({3'd0, v[7:4]} * 7'd10) + {3'd0, v[3:0]};
  endfunction

  function automatic logic leap_yr(input logic [7:0] y);
    logic [6:0] b;
    b = bcd_val(y);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fmt12,
  input  logic ld_tod,
  input  logic ld_cal,
  input  tod_t tod_wr,
  input  cal_t cal_wr,
  output tod_t tod_q,
  output cal_t cal_q,
  output tod_t tod_step,
  output logic step
);

  tod_t       tod_d;
  cal_t       cal_d, cal_step;
  logic       tod_en, cal_en;
  logic       sec_wrap, min_wrap, day_roll, new_day;
  logic [7:0] hr_inc, mdays;
  logic       pm_inc;

  always_comb begin
    step     = tick & ~ld_tod & ~ld_cal;
    sec_wrap = (tod_q.sec == 8'h59);
    min_wrap = (tod_q.min == 8'h59);

    hr_inc   = bcd_inc(tod_q.hour);
    pm_inc   = tod_q.pm;
    day_roll = 1'b0;
    if (fmt12) begin
      if (tod_q.hour == 8'h12) begin
        hr_inc = 8'h01;
      end else if (tod_q.hour == 8'h11) begin
        hr_inc   = 8'h12;
        pm_inc   = ~tod_q.pm;
        day_roll = tod_q.pm;
      end
    end else begin
      pm_inc = 1'b0;
      if (tod_q.hour == 8'h23) begin
        hr_inc   = 8'h00;
        day_roll = 1'b1;
      end
    end

    tod_step     = tod_q;
    tod_step.sec = sec_wrap ? 8'h00 : bcd_inc(tod_q.sec);
    if (sec_wrap) begin
      tod_step.min = min_wrap ? 8'h00 : bcd_inc(tod_q.min);
      if (min_wrap) begin
        tod_step.hour = hr_inc;
        tod_step.pm   = pm_inc;
      end
    end
    new_day = sec_wrap & min_wrap & day_roll;

    mdays    = month_days(cal_q.mon, leap_yr(cal_q.year));
    cal_step = cal_q;
    if (new_day) begin
      cal_step.wday = (cal_q.wday == 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
      if (cal_q.day == mdays) begin
        cal_step.day = 8'h01;
        if (cal_q.mon == 8'h12) begin
          cal_step.mon  = 8'h01;
          cal_step.year = (cal_q.year == 8'h99) ? 8'h00 : bcd_inc(cal_q.year);
        end else begin
          cal_step.mon = bcd_inc(cal_q.mon);
        end
      end else begin
        cal_step.day = bcd_inc(cal_q.day);
      end
    end

    tod_en = ld_tod | step;
    cal_en = ld_cal | step;
    tod_d  = ld_tod ? tod_wr : tod_step;
    cal_d  = ld_cal ? cal_wr : cal_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q <= '0;
      cal_q <= '{wday: 3'd1, year: 8'h00, mon: 8'h01, day: 8'h01};
    end else begin
      if (tod_en) tod_q <= tod_d;
      if (cal_en) cal_q <= cal_d;
    end
  end

  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (tod_q.sec[3:0] <= 4'd9 && tod_q.sec <= 8'h59));

  // R4
  day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cal_q.day != 8'h00 && cal_q.day <= month_days(cal_q.mon, leap_yr(cal_q.year))));

  // R5
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cal_q.wday >= 3'd1 && cal_q.wday <= 3'd7));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_tod |=> (tod_q == $past(tod_wr)));

endmodule

// File: rtl/rtc_wakeup_timer.sv
module rtc_wakeup_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] rld_q,
  output logic         pulse
);

  logic [W-1:0] cnt_q, cnt_d, rld_d;
  logic         hit;

  always_comb begin
    hit   = en & tick & ~ld & (cnt_q == '0);
    rld_d = ld ? ld_val : rld_q;
    if (ld)            cnt_d = ld_val;
    else if (!en)      cnt_d = rld_q;
    else if (tick)     cnt_d = hit ? rld_q : cnt_q - 1'b1;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ld) rld_q <= rld_d;
      pulse <= hit;
    end
  end

  // R8
  wk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick));

endmodule

// File: rtl/rtc_backup_bank.sv
module rtc_backup_bank #(
  parameter int N = 20,
  parameter int W = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tamper,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  logic [N-1:0][W-1:0] mem;
  logic [N-1:0]        wen;
  logic [W-1:0]        wval;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign wen[g] = tamper | (we && (32'(widx) == g));
  end

  assign wval = tamper ? '0 : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wen[i]) mem[i] <= wval;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(ridx) < 32'(N)) rdata = mem[ridx];
  end

  // R10
  tamper_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tamper |=> (mem == '0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int BKP_NUM  = 20,
  parameter int WK_W     = 16,
  parameter int ADDR_W   = 6,
  parameter int BKP_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              tamper,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              alarm_flag,
  output logic              wake_pulse
);

  localparam int DW    = 32;
  localparam int IDX_W = (BKP_NUM > 1) ? $clog2(BKP_NUM) : 1;
  localparam logic [ADDR_W-1:0] A_TOD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CAL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_WK  = ADDR_W'(4);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic ld_tod, ld_cal, ld_ctl, ld_alm, ld_wk, bkp_we, rd_bkp;
  logic [IDX_W-1:0] bkp_widx, bkp_ridx;
  tod_t tod_wr, tod_q, tod_step, alm_q;
  cal_t cal_wr, cal_q;
  logic step, alm_hit, flag_d;
  logic fmt12_q, alm_en_q, wk_en_q;
  logic [WK_W-1:0] wk_rld;
  logic [DW-1:0]   bkp_rdata;

  always_comb begin
    ld_tod   = wr_en && (wr_addr == A_TOD);
    ld_cal   = wr_en && (wr_addr == A_CAL);
    ld_ctl   = wr_en && (wr_addr == A_CTL);
    ld_alm   = wr_en && (wr_addr == A_ALM);
    ld_wk    = wr_en && (wr_addr == A_WK);
    bkp_we   = wr_en && (32'(wr_addr) >= 32'(BKP_BASE)) && (32'(wr_addr) < 32'(BKP_BASE + BKP_NUM));
    rd_bkp   = (32'(rd_addr) >= 32'(BKP_BASE)) && (32'(rd_addr) < 32'(BKP_BASE + BKP_NUM));
    bkp_widx = IDX_W'(wr_addr - ADDR_W'(BKP_BASE));
    bkp_ridx = IDX_W'(rd_addr - ADDR_W'(BKP_BASE));
    tod_wr   = '{pm: wr_data[24], hour: wr_data[23:16], min: wr_data[15:8], sec: wr_data[7:0]};
    cal_wr   = '{wday: wr_data[26:24], year: wr_data[23:16], mon: wr_data[15:8], day: wr_data[7:0]};
  end

  rtc_time_core u_core (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tick     (tick_1hz),
    .fmt12    (fmt12_q),
    .ld_tod   (ld_tod),
    .ld_cal   (ld_cal),
    .tod_wr   (tod_wr),
    .cal_wr   (cal_wr),
    .tod_q    (tod_q),
    .cal_q    (cal_q),
    .tod_step (tod_step),
    .step     (step)
  );

  rtc_wakeup_timer #(.W(WK_W)) u_wake (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick   (tick_1hz),
    .en     (wk_en_q),
    .ld     (ld_wk),
    .ld_val (wr_data[WK_W-1:0]),
    .rld_q  (wk_rld),
    .pulse  (wake_pulse)
  );

  rtc_backup_bank #(.N(BKP_NUM), .W(DW)) u_bkp (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tamper (tamper),
    .we     (bkp_we),
    .widx   (bkp_widx),
    .wdata  (wr_data),
    .ridx   (bkp_ridx),
    .rdata  (bkp_rdata)
  );

  // alarm compares against the value the tick is about to store
  always_comb begin
    alm_hit = alm_en_q && step &&
              (tod_step.sec == alm_q.sec) && (tod_step.min == alm_q.min) &&
              (tod_step.hour == alm_q.hour) &&
              (!fmt12_q || (tod_step.pm == alm_q.pm));
    if (alm_hit)                  flag_d = 1'b1;
    else if (ld_ctl && wr_data[8]) flag_d = 1'b0;
    else                          flag_d = alarm_flag;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      fmt12_q    <= 1'b0;
      alm_en_q   <= 1'b0;
      wk_en_q    <= 1'b0;
      alm_q      <= '0;
      alarm_flag <= 1'b0;
    end else begin
      if (ld_ctl) begin
        fmt12_q  <= wr_data[0];
        alm_en_q <= wr_data[1];
        wk_en_q  <= wr_data[2];
      end
      if (ld_alm) alm_q <= tod_wr;
      alarm_flag <= flag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TOD:   rd_data = {7'd0, tod_q.pm, tod_q.hour, tod_q.min, tod_q.sec};
      A_CAL:   rd_data = {5'd0, cal_q.wday, cal_q.year, cal_q.mon, cal_q.day};
      A_CTL:   rd_data = {23'd0, alarm_flag, 5'd0, wk_en_q, alm_en_q, fmt12_q};
      A_ALM:   rd_data = {7'd0, alm_q.pm, alm_q.hour, alm_q.min, alm_q.sec};
      A_WK:    rd_data = DW'(wk_rld);
      default: if (rd_bkp) rd_data = bkp_rdata;
    endcase
  end

  // R7
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(alarm_flag) |-> $past(step));

  // R7
  alarm_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ld_ctl && wr_data[8] && !alm_hit) |=> !alarm_flag);

endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        tamper = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        alarm_flag, wake_pulse;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  rtc_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tamper(tamper),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .alarm_flag(alarm_flag), .wake_pulse(wake_pulse)
  );

  function automatic logic [7:0] b(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(6'd0, d); chk("R1 time reset", d, 32'h0000_0000);
    rd(6'd1, d); chk("R1 cal reset", d, 32'h0100_0101);
    rd(6'd2, d); chk("R1 ctl reset", d, 32'h0);
    chk("R1 flags reset", {30'd0, alarm_flag, wake_pulse}, 32'h0);

    // R2 one full day, tick every cycle
    tick_1hz = 1'b1;
    for (int n = 1; n <= 86400; n++) begin
      @(negedge clk);
      if (n == 86400) tick_1hz = 1'b0;
      if (n % 97 == 0 || n == 86400) begin
        rd(6'd0, d);
        chk("R2 day sweep", d, {8'd0, b((n / 3600) % 24), b((n / 60) % 60), b(n % 60)});
      end
    end
    rd(6'd1, d); chk("R2 day advance at midnight", d, 32'h0200_0102);

    // R4 R5 last days of every month of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int last, nm, ny;
        last = mdays(m, y);
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        wr(6'd1, {5'd0, 3'd6, b(y), b(m), b(last - 1)});
        wr(6'd0, 32'h0023_5959);
        tick();
        rd(6'd1, d); chk("R4 no early wrap", d, {5'd0, 3'd7, b(y), b(m), b(last)});
        wr(6'd0, 32'h0023_5959);
        tick();
        rd(6'd1, d); chk("R5 month wrap", d, {5'd0, 3'd1, b(ny), b(nm), 8'h01});
      end
    end

    // R3 12-hour sequence across all 24 hours
    wr(6'd2, 32'h1);
    for (int idx = 0; idx < 24; idx++) begin
      int h, nx, nh;
      h  = (idx % 12 == 0) ? 12 : idx % 12;
      nx = (idx + 1) % 24;
      nh = (nx % 12 == 0) ? 12 : nx % 12;
      wr(6'd1, 32'h0324_0515);
      wr(6'd0, {7'd0, (idx >= 12), b(h), 8'h59, 8'h59});
      tick();
      rd(6'd0, d); chk("R3 12h hour step", d, {7'd0, (nx >= 12), b(nh), 8'h00, 8'h00});
      rd(6'd1, d); chk("R3 12h day advance", d, (nx == 0) ? 32'h0424_0516 : 32'h0324_0515);
    end
    wr(6'd2, 32'h0);

    // R6 write wins over a tick in the same cycle
    wr_tick(6'd0, 32'h0000_0030);
    rd(6'd0, d); chk("R6 time write suppresses tick", d, 32'h0000_0030);
    wr_tick(6'd1, 32'h0299_1231);
    rd(6'd0, d); chk("R6 cal write suppresses tick", d, 32'h0000_0030);
    rd(6'd1, d); chk("R6 cal loaded", d, 32'h0299_1231);
    tick();
    rd(6'd0, d); chk("R6 tick resumes", d, 32'h0000_0031);

    // R7 alarm, 24-hour mode
    wr(6'd2, 32'h2);
    wr(6'd3, 32'h0010_2005);
    wr(6'd0, 32'h0010_2003);
    tick(); chk("R7 no match", {31'd0, alarm_flag}, 32'h0);
    tick(); chk("R7 match sets flag", {31'd0, alarm_flag}, 32'h1);
    tick(); chk("R7 flag sticky", {31'd0, alarm_flag}, 32'h1);
    rd(6'd2, d); chk("R7 flag in ctl", d, 32'h102);
    wr(6'd2, 32'h102);
    chk("R7 flag cleared", {31'd0, alarm_flag}, 32'h0);
    wr(6'd2, 32'h0);
    wr(6'd0, 32'h0010_2004);
    tick(); chk("R7 disabled no flag", {31'd0, alarm_flag}, 32'h0);
    // R7 12-hour mode checks the afternoon bit
    wr(6'd2, 32'h3);
    wr(6'd3, 32'h0110_2005);
    wr(6'd0, 32'h0010_2004);
    tick(); chk("R7 pm mismatch", {31'd0, alarm_flag}, 32'h0);
    wr(6'd0, 32'h0110_2004);
    tick(); chk("R7 pm match", {31'd0, alarm_flag}, 32'h1);
    wr(6'd2, 32'h100);

    // R8 wakeup every 4th tick
    wr(6'd4, 32'd3);
    rd(6'd4, d); chk("R8 reload readback", d, 32'd3);
    wr(6'd2, 32'h4);
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk("R8 pulse on tick", {31'd0, wake_pulse}, {31'd0, (k % 4 == 0)});
      @(negedge clk);
      chk("R8 pulse one cycle", {31'd0, wake_pulse}, 32'h0);
    end
    wr(6'd2, 32'h0);

    // R9 backup words
    for (int i = 0; i < 20; i++) wr(6'(32 + i), {8'(i), ~8'(i), 16'h5A00 + 16'(i)});
    for (int i = 0; i < 20; i++) begin
      rd(6'(32 + i), d); chk("R9 backup readback", d, {8'(i), ~8'(i), 16'h5A00 + 16'(i)});
    end

    // R10 tamper wipes all, write in same cycle ignored
    tamper = 1'b1; wr_en = 1'b1; wr_addr = 6'd35; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    tamper = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rd(6'(32 + i), d); chk("R10 tamper wipe", d, 32'h0);
    end
    wr(6'd40, 32'hCAFE_0001);
    rd(6'd40, d); chk("R9 write after tamper", d, 32'hCAFE_0001);

    done = 1;
    summary();
    $finish;
  end

endmodule